// File: doc/BRIEF.md
# Eight-Bit I/O Port with Pin-Change Interrupt

This block is one general-purpose I/O port that sits on a simple register bus. Software chooses, per pin, whether the block drives the pin or only listens to it. It sets the levels on the driven pins and reads back the level every pin actually carries. When a driven pin takes its level from the output register, that level is what the port reports and what the change logic sees. When a pin is an input, the external level is used instead.

A pin-change unit compares the effective pin vector with its value at the previous clock edge. A change on any pin enabled in the mask register sets a sticky pending flag. The flag raises the interrupt request only while the enable bit in the control register is set. A flag caught while the request is disabled stays pending and raises the request as soon as the enable bit is set.

The flag is cleared in two ways: software writes a one to its bit, or the interrupt controller pulses an acknowledge. Writes that carry a zero in the flag bit leave a pending event in place. A new change arriving in the same cycle as a clear wins, so no event is lost.

Top module: `gpio_pc_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: A write to DIR (address 1) or OUT (address 2) is read back at that address, and it appears on `pin_oe` / `pin_out` from the clock edge that takes the write.
- R3: Reading PIN (address 0) returns, combinationally, the OUT bit for each pin whose DIR bit is 1 and the `pin_in` bit for each pin whose DIR bit is 0.
- R4: When the effective pin vector differs from its value at the previous edge on a bit whose MASK (address 3) bit is 1, the flag (bit 0 of FLAG, address 5) reads 1 after the next clock edge.
- R5: A change on a pin whose MASK bit is 0 does not set the flag. With MASK = 3, only pins 0 and 1 can set it.
- R6: On a pin driven as an output, a write to OUT that changes a masked pin sets the flag one edge after the write edge, the same as an external change.
- R7: A write to FLAG with bit 0 set clears the flag. A write with bit 0 clear, for example 0x06, leaves a pending flag set.
- R8: A one-cycle pulse on `irq_ack` clears the flag.
- R9: `irq` is high exactly when the flag is set and bit 0 of CTRL (address 4) is 1. A flag set while CTRL bit 0 is 0 stays pending, and raises `irq` once the bit is written to 1.
- R10: If a masked change is detected in the same cycle as a flag clear (a write-one or `irq_ack`), the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Output register driven to the pads |
| pin_oe | output | 8 | Per-pin output enable (direction) |
| irq_ack | input | 1 | Acknowledge from the interrupt controller, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge that takes them, and PIN reads are combinational, so they are checked at the falling edge right after the write. An external pin change shows in the flag one edge later. A change made by a write to OUT needs one more edge, because the new output level has to be compared against the registered previous level. The bench drives every stimulus on a falling edge and samples on a later falling edge. For OUT-driven changes it first confirms that the flag is still clear one edge early, then confirms it is set one edge later. The priority case lines up the write-one, the acknowledge and the detected change in a single cycle.

// File: rtl/gpio_pc_pkg.sv
package gpio_pc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PIN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_OUT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd5;
  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 0;
endpackage

// File: rtl/gpio_pc_regs.sv
module gpio_pc_regs
  import gpio_pc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  ctrl_q
);
  logic wr_dir, wr_out, wr_mask, wr_ctrl;
  assign wr_dir  = we && (addr == A_DIR);
  assign wr_out  = we && (addr == A_OUT);
  assign wr_mask = we && (addr == A_MASK);
  assign wr_ctrl = we && (addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_out)  out_q  <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
    end
  end

  AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DIR) |=> (dir_q == $past(wdata))); // R2
  AST_OUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_OUT) |=> (out_q == $past(wdata))); // R2
endmodule

// File: rtl/gpio_pc_detect.sv
module gpio_pc_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] eff_pins,
  output logic             pc_event
);
  function automatic logic [WIDTH-1:0] pick_level(
    input logic [WIDTH-1:0] dir, input logic [WIDTH-1:0] drv, input logic [WIDTH-1:0] ext);
    return (dir & drv) | (~dir & ext);
  endfunction

  function automatic logic masked_diff(
    input logic [WIDTH-1:0] now_v, input logic [WIDTH-1:0] old_v, input logic [WIDTH-1:0] msk);
    return |((now_v ^ old_v) & msk);
  endfunction

  logic [WIDTH-1:0] prev_q;

  assign eff_pins = pick_level(dir_q, out_q, pin_in);
  assign pc_event = masked_diff(eff_pins, prev_q, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= eff_pins;
  end

  AST_NO_EVENT_WHEN_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !pc_event); // R5
endmodule

// File: rtl/gpio_pc_flag.sv
module gpio_pc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pc_event,
  input  logic sw_clear,
  input  logic irq_ack,
  output logic flag_q
);
  logic clr_any;
  assign clr_any = sw_clear || irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (pc_event) flag_q <= 1'b1;
    else if (clr_any)  flag_q <= 1'b0;
  end

  AST_FLAG_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pc_event |=> flag_q); // R4
  AST_FLAG_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(pc_event)); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !pc_event) |=> !flag_q); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !pc_event) |=> !flag_q); // R8
  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_clear && !irq_ack) |=> flag_q); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_event && clr_any) |=> flag_q); // R10
endmodule

// File: rtl/gpio_pc_port.sv
module gpio_pc_port
  import gpio_pc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic              irq_ack,
  output logic              irq
);
  logic [WIDTH-1:0] dir_q, out_q, mask_q, ctrl_q, eff_pins;
  logic             pc_event, flag_q, sw_clear, irq_en;

  gpio_pc_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q), .ctrl_q(ctrl_q)
  );

  gpio_pc_detect #(.WIDTH(WIDTH)) u_detect (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .out_q(out_q), .pin_in(pin_in),
    .mask_q(mask_q), .eff_pins(eff_pins), .pc_event(pc_event)
  );

  assign sw_clear = bus_we && (bus_addr == A_FLAG) && bus_wdata[FLAG_BIT];

  gpio_pc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .pc_event(pc_event), .sw_clear(sw_clear),
    .irq_ack(irq_ack), .flag_q(flag_q)
  );

  assign irq_en  = ctrl_q[EN_BIT];
  assign irq     = flag_q && irq_en;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_PIN:   bus_rdata = eff_pins;
      A_DIR:   bus_rdata = dir_q;
      A_OUT:   bus_rdata = out_q;
      A_MASK:  bus_rdata = mask_q;
      A_CTRL:  bus_rdata = ctrl_q;
      A_FLAG:  bus_rdata[FLAG_BIT] = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[EN_BIT]); // R9
  AST_IRQ_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_clear && !irq_ack && bus_we && bus_addr == A_CTRL && bus_wdata[EN_BIT]) |=> irq); // R9
endmodule

// File: tb/sim_gpio_pc_port.sv
module sim_gpio_pc_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         irq_ack = 1'b0;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio_pc_port #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_ack(irq_ack), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench's own view of the effective pin level, bit by bit.
  function automatic logic [W-1:0] model_pins(input logic [W-1:0] d, input logic [W-1:0] o,
                                              input logic [W-1:0] e);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = d[i] ? o[i] : e[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      check("R1 reg", v, '0);
    end
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_dir_out();
    logic [W-1:0] v;
    wr(3'd1, 8'hF0);
    wr(3'd2, 8'hA5);
    check("R2 pin_oe", pin_oe, 8'hF0);
    check("R2 pin_out", pin_out, 8'hA5);
    rd(3'd1, v); check("R2 DIR read", v, 8'hF0);
    rd(3'd2, v); check("R2 OUT read", v, 8'hA5);
    pin_in = 8'h3C;
    rd(3'd0, v); check("R3 PIN mixed", v, model_pins(8'hF0, 8'hA5, 8'h3C));
    pin_in = 8'hC3;
    rd(3'd0, v); check("R3 PIN mixed 2", v, model_pins(8'hF0, 8'hA5, 8'hC3));
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    pin_in = 8'h00;
    @(negedge clk);
    rd(3'd5, v); check("R5 no flag with mask 0", v, 8'h00);
  endtask

  task automatic t_external();
    logic [W-1:0] v;
    wr(3'd3, 8'h03);
    wr(3'd4, 8'h01);
    pin_in = 8'h01;
    @(negedge clk);
    rd(3'd5, v); check("R4 external change flag", v, 8'h01);
    check("R9 irq with enable", {7'b0, irq}, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); check("R7 write-one clears", v, 8'h00);
    check("R9 irq drops", {7'b0, irq}, 8'h00);
    pin_in = 8'h21;
    @(negedge clk); @(negedge clk);
    rd(3'd5, v); check("R5 unmasked pin ignored", v, 8'h00);
  endtask

  task automatic t_output();
    logic [W-1:0] v;
    wr(3'd1, 8'hFF);
    @(negedge clk);
    wr(3'd5, 8'h01);
    wr(3'd2, 8'h01);
    rd(3'd5, v); check("R6 not yet at write edge", v, 8'h00);
    @(negedge clk);
    rd(3'd5, v); check("R6 output write sets flag", v, 8'h01);
    wr(3'd5, 8'h06);
    rd(3'd5, v); check("R7 zero-bit write keeps flag", v, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); check("R7 write-one clears", v, 8'h00);
  endtask

  task automatic t_enable();
    logic [W-1:0] v;
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h03);
    @(negedge clk);
    rd(3'd5, v); check("R9 flag pending while disabled", v, 8'h01);
    check("R9 irq low while disabled", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R9 still low", {7'b0, irq}, 8'h00);
    wr(3'd4, 8'h01);
    check("R9 irq after enable", {7'b0, irq}, 8'h01);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    rd(3'd5, v); check("R8 ack clears", v, 8'h00);
    check("R8 irq low after ack", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_priority();
    logic [W-1:0] v;
    wr(3'd2, 8'h01);
    @(negedge clk);
    rd(3'd5, v); check("R6 bit1 falling sets flag", v, 8'h01);
    wr(3'd2, 8'h03);
    // Change is detected at the next edge; clear it in that same cycle.
    bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h01; irq_ack = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; irq_ack = 1'b0;
    rd(3'd5, v); check("R10 set wins over clear", v, 8'h01);
    check("R10 irq held", {7'b0, irq}, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); check("R7 clear with no event", v, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_external();
    t_output();
    t_enable();
    t_priority();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule